// File: doc/BRIEF.md
# Compensated Fixed-Width Truncated Multiplier

This block produces a six-bit estimate of the top of a 12 × 12 product, the bits that carry weights 2^18 to 2^23, without building a full multiplier. It keeps only the upper half of each operand. From those two six-bit halves it forms only the partial products whose column lands on or above the result LSB. The truncated columns are not thrown away blindly.

Every bit product of the highest truncated column (operand half indices i + j = 5) enters the result LSB column as a carry-in. A single extra carry is also added when two things are true together: that column sums to zero, and the column below it (i + j = 4) holds at least one set product. The extra carry is merged by an OR gate with the column-5 product whose multiplier index is highest, so it enters at the bottom of the compensation vector.

The estimate is meant to sit beside a slower full-precision multiplier as a cheap replica of its upper bits. The result is registered once, so it appears one clock after the operands are sampled. The estimate is an unsigned six-bit value.

Top module: `fw_trunc_mult`

## Requirements
- R1: While the active-low reset is asserted, the output is 0.
- R2: Bits 5..0 of either operand have no effect on the result. Only bits 11..6 (call them A and B, with A[i] = x_in[6+i] and B[j] = y_in[6+j]) are used.
- R3: The result for operands sampled at one rising clock edge appears at the output after that edge and is held until the next edge.
- R4: The result equals the sum of three parts, taken modulo 64. The first part is A[i]·B[j]·2^(i+j-6) over every pair with i + j ≥ 6. The second part is the count of set products in column i + j = 5. The third part is one extra unit in the case defined by R6.
- R5: When column i + j = 5 holds at least one set product, the compensation is exactly that count of set products. The lower column then has no influence.
- R6: When column i + j = 5 holds no set product and column i + j = 4 holds at least one, the compensation is exactly 1.
- R7: When both columns i + j = 5 and i + j = 4 are all zero, the compensation is 0.
- R8: With both upper halves all ones, the result is 63 (kept columns contribute 57, compensation 6).
- R9: If either upper half is zero, the result is 0.
- R10: With B = 6'b100000, the result is (A >> 1) + A[0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_in | input | 12 | First unsigned operand |
| y_in | input | 12 | Second unsigned operand |
| prod_out | output | 6 | Registered estimate of product bits 23..18 |

## Verification
Two things can land on the result LSB in the same cycle: the conditional extra carry, and the carry-ins from the top truncated column. By construction the two can never be active together. The case worth judging is the extra carry arriving alongside a ripple from the kept columns, which pushes a carry through several result bits at once.

An exhaustive sweep over all 4096 pairs of upper halves provokes every such combination, with the low operand bits scrambled at the same time. Each result is compared against an arithmetic model in the bench. Each check is tagged by which compensation case applied: the column sum, the extra carry, or no compensation.

// File: rtl/fwm_pkg.sv
package fwm_pkg;
    localparam int OP_W  = 12;
    localparam int HALF  = OP_W / 2;
    localparam int RES_W = HALF;
    localparam int ACC_W = 2 * HALF;
    typedef logic [HALF-1:0]           half_t;
    typedef logic [HALF-1:0][HALF-1:0] pp_grid_t;
endpackage

// File: rtl/fwm_ppgen.sv
module fwm_ppgen
    import fwm_pkg::*;
(
    input  half_t    a_half,
    input  half_t    b_half,
    output pp_grid_t pp
);
    for (genvar gi = 0; gi < HALF; gi++) begin : g_row
        for (genvar gj = 0; gj < HALF; gj++) begin : g_col
            assign pp[gi][gj] = a_half[gi] & b_half[gj];
        end
    end
endmodule

// File: rtl/fwm_comp.sv
module fwm_comp
    import fwm_pkg::*;
(
    input  logic [HALF-1:0] top_col,
    input  logic [HALF-2:0] next_col,
    output logic [HALF-1:0] inject
);
    logic top_empty;
    logic next_busy;
    logic extra_carry;

    assign top_empty   = ~(|top_col);
    assign next_busy   = |next_col;
    assign extra_carry = top_empty & next_busy;

    always_comb begin
        inject    = top_col;
        inject[0] = top_col[0] | extra_carry;
    end
endmodule

// File: rtl/fwm_accum.sv
module fwm_accum
    import fwm_pkg::*;
(
    input  pp_grid_t        pp,
    input  logic [HALF-1:0] inject,
    output logic [RES_W-1:0] sum_out
);
    logic [ACC_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < HALF; i++) begin
            for (int j = 0; j < HALF; j++) begin
                if (i + j >= HALF) begin
                    acc = acc + (ACC_W'(pp[i][j]) << (i + j - HALF));
                end
            end
        end
        for (int k = 0; k < HALF; k++) begin
            acc = acc + ACC_W'(inject[k]);
        end
        sum_out = acc[RES_W-1:0];
    end
endmodule

// File: rtl/fw_trunc_mult.sv
module fw_trunc_mult
    import fwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  x_in,
    input  logic [OP_W-1:0]  y_in,
    output logic [RES_W-1:0] prod_out
);
    half_t            a_half;
    half_t            b_half;
    pp_grid_t         pp;
    logic [HALF-1:0]  top_col;
    logic [HALF-2:0]  next_col;
    logic [HALF-1:0]  inject;
    logic [RES_W-1:0] sum_next;
    logic             unused_low;

    assign a_half     = x_in[OP_W-1:HALF];
    assign b_half     = y_in[OP_W-1:HALF];
    assign unused_low = ^{x_in[HALF-1:0], y_in[HALF-1:0]};

    fwm_ppgen u_ppgen (
        .a_half (a_half),
        .b_half (b_half),
        .pp     (pp)
    );

    for (genvar gt = 0; gt < HALF; gt++) begin : g_top
        assign top_col[gt] = pp[gt][HALF-1-gt];
    end
    for (genvar gn = 0; gn < HALF-1; gn++) begin : g_next
        assign next_col[gn] = pp[gn][HALF-2-gn];
    end

    fwm_comp u_comp (
        .top_col  (top_col),
        .next_col (next_col),
        .inject   (inject)
    );

    fwm_accum u_accum (
        .pp      (pp),
        .inject  (inject),
        .sum_out (sum_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_out <= '0;
        end else begin
            prod_out <= sum_next;
        end
    end
endmodule

// File: rtl/fwm_checker.sv
module fwm_checker
    import fwm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [OP_W-1:0]  x_in,
    input logic [OP_W-1:0]  y_in,
    input logic [RES_W-1:0] prod_out
);
    logic [1:0] warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= '0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    AST_LOW_BITS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && $past(x_in[OP_W-1:HALF]) == $past(x_in[OP_W-1:HALF], 2)
         && $past(y_in[OP_W-1:HALF]) == $past(y_in[OP_W-1:HALF], 2)) |-> $stable(prod_out)); // R2

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (x_in[OP_W-1:HALF] == '0 || y_in[OP_W-1:HALF] == '0) |=> prod_out == '0); // R9

    AST_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (&x_in[OP_W-1:HALF] && &y_in[OP_W-1:HALF]) |=> prod_out == 6'd63); // R8

    AST_TOP_BIT_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        (y_in[OP_W-1:HALF] == 6'b100000) |=>
        prod_out == (6'($past(x_in[OP_W-1:HALF+1])) + 6'($past(x_in[HALF])))); // R10
endmodule

bind fw_trunc_mult fwm_checker u_chk (.*);

// File: tb/fw_trunc_mult_bench.sv
module fw_trunc_mult_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] x_in = '0;
    logic [11:0] y_in = '0;
    logic [5:0]  prod_out;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5ns clk = ~clk;

    fw_trunc_mult u_fw_trunc_mult (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .y_in(y_in), .prod_out(prod_out)
    );

    function automatic int col_count(input logic [11:0] x, input logic [11:0] y, input int col);
        int n = 0;
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                if (i + j == col && x[6+i] && y[6+j]) n++;
        return n;
    endfunction

    function automatic logic [5:0] model(input logic [11:0] x, input logic [11:0] y);
        int s = 0;
        int c5 = col_count(x, y, 5);
        int c4 = col_count(x, y, 4);
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                if (i + j >= 6 && x[6+i] && y[6+j]) s += 1 << (i + j - 6);
        s += c5;
        if (c5 == 0 && c4 != 0) s += 1;
        return 6'(s % 64);
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s x=%h y=%h actual=%0d expected=%0d", req, x_in, y_in, act, exp);
        end
    endtask

    task automatic apply(input logic [11:0] x, input logic [11:0] y, input string req);
        @(negedge clk);
        x_in = x;
        y_in = y;
        @(negedge clk);
        check(req, prod_out, model(x, y));
    endtask

    task automatic apply_fixed(input logic [11:0] x, input logic [11:0] y,
                               input string req, input logic [5:0] exp);
        @(negedge clk);
        x_in = x;
        y_in = y;
        @(negedge clk);
        check(req, prod_out, exp);
    endtask

    initial begin
        #1ms;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        x_in = 12'hFFF;
        y_in = 12'hFFF;
        repeat (3) @(negedge clk);
        check("R1 reset", prod_out, 6'd0);
        rst_n = 1'b1;
        @(negedge clk);
        x_in = 12'h000;
        #1ns;
        check("R1 first result", prod_out, 6'd63);

        apply_fixed({6'b111111, 6'h0}, {6'b111111, 6'h0}, "R8 all ones", 6'd63);
        apply_fixed({6'b100000, 6'h2A}, {6'b000001, 6'h15}, "R5 single top-column product", 6'd1);
        apply_fixed({6'b000010, 6'h3F}, {6'b001000, 6'h00}, "R6 extra carry", 6'd1);
        apply_fixed({6'b000001, 6'h3F}, {6'b000001, 6'h3F}, "R7 no compensation", 6'd0);
        apply_fixed({6'b000000, 6'h3F}, {6'b111111, 6'h3F}, "R9 zero operand", 6'd0);
        apply_fixed({6'b101101, 6'h00}, {6'b100000, 6'h07}, "R10 top bit halves", 6'd23);
        apply_fixed({6'b110011, 6'h11}, {6'b101010, 6'h22}, "R4 mixed", model({6'b110011, 6'h0}, {6'b101010, 6'h0}));

        apply({6'b011011, 6'h00}, {6'b110101, 6'h00}, "R2 low bits zero");
        apply({6'b011011, 6'h3F}, {6'b110101, 6'h2C}, "R2 low bits set");

        @(negedge clk);
        x_in = {6'b111111, 6'h0};
        y_in = {6'b111111, 6'h0};
        @(negedge clk);
        x_in = 12'h000;
        #1ns;
        check("R3 hold before edge", prod_out, 6'd63);
        @(negedge clk);
        check("R3 update after edge", prod_out, 6'd0);

        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
                logic [11:0] xv;
                logic [11:0] yv;
                string tag;
                xv = {6'(a), 6'((a * 7 + b * 13) % 64)};
                yv = {6'(b), 6'((a * 29 + b * 3) % 64)};
                if (col_count(xv, yv, 5) != 0) tag = "R5 sweep";
                else if (col_count(xv, yv, 4) != 0) tag = "R6 sweep";
                else tag = "R7 sweep";
                apply(xv, yv, tag);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule